// File: doc/BRIEF.md
# DRAM Command Decoder and Bank State Tracker

This block watches the command pins of a double-data-rate synchronous DRAM on every rising clock edge and turns them into one decoded command code. It tells apart deselect, no-operation, the two mode register loads, auto refresh, self-refresh entry and exit, row activate, read, write, burst stop, single-bank and all-bank precharge, and power-down entry and exit. The clock-enable pin is registered inside the block, so its level at the previous edge is compared with its level at the current edge.

Alongside the decode it keeps a small model of the memory array: for each of four banks, whether a row is open and which row it is, plus whether an auto-precharge is pending. It also tracks the power state and a short lockout window after a mode register load. Every decoded command is checked against this state. A command that is not allowed raises an illegal flag and changes nothing. A memory controller under test or a protocol monitor on a board model can use the flag to catch ordering bugs.

Top module: `dram_cmd_monitor`

## Requirements
- R1: All outputs are registered. After a command is sampled at a rising edge, `cmd_code` and `illegal` show it, and `bank_open`, `open_rows` and `pd_mode` show the state that results from it. During reset `cmd_code`=0, `illegal`=0, all banks are idle, `open_rows`=0 and `pd_mode`=0.
- R2: With clock enable high at the previous and the current edge, `cs_n` high decodes as deselect (code 0). With `cs_n` low, the pins {ras_n,cas_n,we_n} decode as follows: 111 no-op (1), 000 mode load (2 when BA=00, extended load 3 otherwise), 001 auto refresh (4), 011 activate (7), 101 read (8), 100 write (9), 110 burst stop (10), 010 precharge (11 when A10=0, all-bank precharge 12 when A10=1).
- R3: Clock enable high at the previous edge and low now decodes as self-refresh entry (5) if `cs_n`=0 and the pins are 001, and as power-down entry (13) otherwise. Low at the previous edge and high now decodes as self-refresh exit (6) if the block is in self refresh, and as power-down exit (14) otherwise. Low at both edges decodes as hold (15).
- R4: A legal activate opens bank BA (BA value b maps to `bank_open[b]`) and stores A[12:0] in `open_rows[13*b +: 13]`. An activate to a bank that is already open is illegal.
- R5: A read, write or single-bank precharge to a bank with no open row is illegal. A read or write to a bank with an auto-precharge pending is also illegal.
- R6: A legal single-bank precharge closes bank BA. An all-bank precharge closes every bank whatever BA holds, and is never illegal because of bank state.
- R7: A legal read or write with A10=1 closes its bank at the AP_CYCLES-th rising edge after the command's edge (4 by default).
- R8: Mode loads (2, 3), auto refresh (4) and self-refresh entry (5) are illegal while any bank is open.
- R9: After a legal mode load at edge k, any array command (codes 2, 3, 4, 5, 7 to 12) at edge k+1 is illegal. At edge k+2 such commands are allowed again (MRD_CYCLES=2).
- R10: An illegal command changes no bank state, no stored row, no lockout and no power state.
- R11: `pd_mode` is 0 when awake. Power-down entry sets it to 1 if all banks were idle before the edge and to 2 if any bank was open. A legal self-refresh entry sets it to 3. Either exit returns it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke | input | 1 | Clock enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin, active low |
| cas_n | input | 1 | Column strobe command pin, active low |
| we_n | input | 1 | Write enable command pin, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address pins; A10 selects auto-precharge or all banks |
| cmd_code | output | 4 | Decoded command of the last sampled edge |
| illegal | output | 1 | Last sampled command was not allowed in its state |
| bank_open | output | 4 | One bit per bank, 1 when a row is open |
| open_rows | output | 52 | Open row of each bank, 13 bits per bank, bank 0 lowest |
| pd_mode | output | 2 | 0 awake, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
The bench aims at the edge right after a mode load. A block that counted the lockout one cycle short would accept the activate there, and one that counted it one cycle long would reject the activate two edges later. It follows an auto-precharge to the exact closing edge and issues a second read while the precharge is pending. A miscounted timer would drop the bank early or late, and a tracker that ignored the pending flag would accept the read. It tries an all-bank precharge with a non-zero bank address, a self-refresh entry with a bank open, and a power-down entry from both idle and open states. Each would expose a decoder that reads BA when it should not, or that lets an illegal entry change the power state.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL    = 4'd0,
    CMD_NOP      = 4'd1,
    CMD_MRS      = 4'd2,
    CMD_EMRS     = 4'd3,
    CMD_AREF     = 4'd4,
    CMD_SREF_IN  = 4'd5,
    CMD_SREF_OUT = 4'd6,
    CMD_ACT      = 4'd7,
    CMD_RD       = 4'd8,
    CMD_WR       = 4'd9,
    CMD_BST      = 4'd10,
    CMD_PRE      = 4'd11,
    CMD_PREA     = 4'd12,
    CMD_PD_IN    = 4'd13,
    CMD_PD_OUT   = 4'd14,
    CMD_HOLD     = 4'd15
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_AWAKE  = 2'd0,
    PWR_PRE_PD = 2'd1,
    PWR_ACT_PD = 2'd2,
    PWR_SELF   = 2'd3
  } pwr_e;
endpackage

// File: rtl/dcm_decode.sv
module dcm_decode
  import dcm_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_now,
  input  logic            cke_prev,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic            in_self,
  output cmd_e            cmd
);
  logic [2:0] pins;
  assign pins = {ras_n, cas_n, we_n};

  always_comb begin
    cmd = CMD_NOP;
    if (!cke_prev && !cke_now) begin
      cmd = CMD_HOLD;
    end else if (!cke_prev) begin
      cmd = in_self ? CMD_SREF_OUT : CMD_PD_OUT;
    end else if (!cke_now) begin
      cmd = (!cs_n && pins == 3'b001) ? CMD_SREF_IN : CMD_PD_IN;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case (pins)
        3'b000:  cmd = (ba == '0) ? CMD_MRS : CMD_EMRS;
        3'b001:  cmd = CMD_AREF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dcm_bank.sv
module dcm_bank #(
  parameter int ROW_W     = 13,
  parameter int AP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic [ROW_W-1:0] row_in,
  input  logic             close_en,
  input  logic             ap_load,
  output logic             is_open,
  output logic             ap_busy,
  output logic [ROW_W-1:0] row
);
  localparam int CW = $clog2(AP_CYCLES + 1);

  logic          open_q, open_d;
  logic [CW-1:0] ap_q, ap_d;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    open_d = open_q;
    ap_d   = ap_q;
    if (ap_q != '0) begin
      ap_d = ap_q - 1'b1;
      if (ap_q == CW'(1)) open_d = 1'b0;
    end
    if (close_en) begin
      open_d = 1'b0;
      ap_d   = '0;
    end
    if (open_en) open_d = 1'b1;
    if (ap_load) ap_d = CW'(AP_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ap_q   <= '0;
    end else begin
      open_q <= open_d;
      ap_q   <= ap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (open_en) row_q <= row_in;
  end

  assign is_open = open_q;
  assign ap_busy = (ap_q != '0);
  assign row     = row_q;

  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_q == CW'(1) && !open_en) |=> !open_q); // R7
endmodule

// File: rtl/dram_cmd_monitor.sv
module dram_cmd_monitor
  import dcm_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 13,
  parameter int AP_BIT     = 10,
  parameter int AP_CYCLES  = 4,
  parameter int MRD_CYCLES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [1:0]                 ba,
  input  logic [12:0]                addr,
  output logic [3:0]                 cmd_code,
  output logic                       illegal,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic [1:0]                 pd_mode
);
  localparam int LW = $clog2(MRD_CYCLES + 1);

  logic [1:0] rst_pipe;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic   cke_q;
  logic [LW-1:0] lock_q, lock_d;
  pwr_e   pwr_q, pwr_d;
  cmd_e   cmd_q, cmd_now;
  logic   ill_q, ill_now;
  logic [NUM_BANKS-1:0] open_vec, busy_vec, open_en, close_en, ap_load;
  logic   any_open, array_cmd, rule_bad, legal;

  dcm_decode #(.BA_W(2)) u_dec (
    .cke_now (cke),
    .cke_prev(cke_q),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .a10     (addr[AP_BIT]),
    .in_self (pwr_q == PWR_SELF),
    .cmd     (cmd_now)
  );

  assign any_open  = |open_vec;
  assign array_cmd = cmd_now inside {CMD_MRS, CMD_EMRS, CMD_AREF, CMD_SREF_IN,
                                     CMD_ACT, CMD_RD, CMD_WR, CMD_BST,
                                     CMD_PRE, CMD_PREA};

  always_comb begin
    case (cmd_now)
      CMD_MRS, CMD_EMRS, CMD_AREF, CMD_SREF_IN: rule_bad = any_open;
      CMD_ACT:         rule_bad = open_vec[ba];
      CMD_RD, CMD_WR:  rule_bad = !open_vec[ba] || busy_vec[ba];
      CMD_PRE:         rule_bad = !open_vec[ba];
      default:         rule_bad = 1'b0;
    endcase
    ill_now = rule_bad || ((lock_q != '0) && array_cmd);
    legal   = !ill_now;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit         = (ba == 2'(b));
    assign open_en[b]  = legal && cmd_now == CMD_ACT && hit;
    assign close_en[b] = legal && (cmd_now == CMD_PREA || (cmd_now == CMD_PRE && hit));
    assign ap_load[b]  = legal && (cmd_now == CMD_RD || cmd_now == CMD_WR) &&
                         addr[AP_BIT] && hit;
    dcm_bank #(.ROW_W(ROW_W), .AP_CYCLES(AP_CYCLES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_int),
      .open_en (open_en[b]),
      .row_in  (addr[ROW_W-1:0]),
      .close_en(close_en[b]),
      .ap_load (ap_load[b]),
      .is_open (open_vec[b]),
      .ap_busy (busy_vec[b]),
      .row     (open_rows[b*ROW_W +: ROW_W])
    );
  end

  always_comb begin
    lock_d = lock_q;
    if (legal && (cmd_now == CMD_MRS || cmd_now == CMD_EMRS))
      lock_d = LW'(MRD_CYCLES - 1);
    else if (lock_q != '0)
      lock_d = lock_q - 1'b1;

    pwr_d = pwr_q;
    case (cmd_now)
      CMD_PD_IN:               pwr_d = any_open ? PWR_ACT_PD : PWR_PRE_PD;
      CMD_SREF_IN:             if (legal) pwr_d = PWR_SELF;
      CMD_SREF_OUT, CMD_PD_OUT: pwr_d = PWR_AWAKE;
      default:                 pwr_d = pwr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      cke_q  <= 1'b1;
      lock_q <= '0;
      pwr_q  <= PWR_AWAKE;
      cmd_q  <= CMD_DESEL;
      ill_q  <= 1'b0;
    end else begin
      cke_q  <= cke;
      lock_q <= lock_d;
      pwr_q  <= pwr_d;
      cmd_q  <= cmd_now;
      ill_q  <= ill_now;
    end
  end

  assign cmd_code  = cmd_q;
  assign illegal   = ill_q;
  assign bank_open = open_vec;
  assign pd_mode   = pwr_q;

  AST_IDLE_ONLY_CMDS: assert property (@(posedge clk) disable iff (!rst_int)
    ((cmd_q inside {CMD_MRS, CMD_EMRS, CMD_AREF, CMD_SREF_IN}) && !ill_q)
      |-> ($past(open_vec) == '0)); // R8
  AST_LOCK_STARTS: assert property (@(posedge clk) disable iff (!rst_int)
    ((MRD_CYCLES > 1) && (cmd_q inside {CMD_MRS, CMD_EMRS}) && !ill_q)
      |-> (lock_q != '0)); // R9
  AST_SELF_IDLE: assert property (@(posedge clk) disable iff (!rst_int)
    (pwr_q == PWR_SELF) |-> (open_vec == '0)); // R11
  AST_PD_KIND: assert property (@(posedge clk) disable iff (!rst_int)
    (cmd_q == CMD_PD_IN) |-> (pwr_q inside {PWR_PRE_PD, PWR_ACT_PD})); // R11
  AST_ILLEGAL_ACT_KEEPS_ROWS: assert property (@(posedge clk) disable iff (!rst_int)
    (cmd_q == CMD_ACT && ill_q) |-> $stable(open_rows)); // R10
endmodule

// File: tb/dram_cmd_monitor_tb_top.sv
module dram_cmd_monitor_tb_top;
  localparam int AP  = 4;
  localparam int MRD = 2;
  localparam logic [2:0] P_NOP = 3'b111, P_MRS = 3'b000, P_REF = 3'b001,
                         P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_BST = 3'b110, P_PRE = 3'b010;

  logic clk = 1'b0;
  logic rst_n;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] addr;
  logic [3:0] cmd_code;
  logic illegal;
  logic [3:0] bank_open;
  logic [51:0] open_rows;
  logic [1:0] pd_mode;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  bit        m_open [4];
  bit [12:0] m_row  [4];
  int        m_ap   [4];
  int        m_lock;
  int        m_pwr;
  bit        m_cke;

  always #5 clk = ~clk;

  dram_cmd_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .illegal(illegal), .bank_open(bank_open), .open_rows(open_rows),
    .pd_mode(pd_mode)
  );

  function automatic bit [51:0] exp_rows();
    return {m_row[3], m_row[2], m_row[1], m_row[0]};
  endfunction

  function automatic bit [3:0] exp_open();
    return {m_open[3], m_open[2], m_open[1], m_open[0]};
  endfunction

  task automatic check(input string tag, input int ecmd, input bit eill);
    n_tests++;
    if (cmd_code !== 4'(ecmd) || illegal !== eill || bank_open !== exp_open() ||
        open_rows !== exp_rows() || pd_mode !== 2'(m_pwr)) begin
      n_fail++;
      $display("FAIL %s: got cmd=%0d ill=%0b open=%b rows=%h pd=%0d exp cmd=%0d ill=%0b open=%b rows=%h pd=%0d",
               tag, cmd_code, illegal, bank_open, open_rows, pd_mode,
               ecmd, eill, exp_open(), exp_rows(), m_pwr);
    end
  endtask

  task automatic apply(input bit ck, input bit cs, input logic [2:0] pins,
                       input logic [1:0] b, input logic [12:0] a, input string tag);
    int ecmd;
    bit eill, bad, arr, anyo;
    @(negedge clk);
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = pins; ba = b; addr = a;
    // expected command (R2, R3)
    if (!m_cke && !ck)   ecmd = 15;
    else if (!m_cke)     ecmd = (m_pwr == 3) ? 6 : 14;
    else if (!ck)        ecmd = (!cs && pins == P_REF) ? 5 : 13;
    else if (cs)         ecmd = 0;
    else case (pins)
      P_MRS: ecmd = (b == 2'd0) ? 2 : 3;
      P_REF: ecmd = 4;
      P_ACT: ecmd = 7;
      P_RD:  ecmd = 8;
      P_WR:  ecmd = 9;
      P_BST: ecmd = 10;
      P_PRE: ecmd = a[10] ? 12 : 11;
      default: ecmd = 1;
    endcase
    anyo = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    arr  = ecmd inside {2, 3, 4, 5, 7, 8, 9, 10, 11, 12};
    case (ecmd)
      2, 3, 4, 5: bad = anyo;
      7:          bad = m_open[b];
      8, 9:       bad = !m_open[b] || (m_ap[b] != 0);
      11:         bad = !m_open[b];
      default:    bad = 1'b0;
    endcase
    eill = bad || (m_lock != 0 && arr);
    // state after the edge
    for (int i = 0; i < 4; i++)
      if (m_ap[i] != 0) begin
        m_ap[i]--;
        if (m_ap[i] == 0) m_open[i] = 1'b0;
      end
    if (!eill && (ecmd == 2 || ecmd == 3)) m_lock = MRD - 1;
    else if (m_lock != 0) m_lock--;
    if (!eill) begin
      case (ecmd)
        7:  begin m_open[b] = 1'b1; m_row[b] = a; end
        11: begin m_open[b] = 1'b0; m_ap[b] = 0; end
        12: for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; m_ap[i] = 0; end
        8, 9: if (a[10]) m_ap[b] = AP;
        5:  m_pwr = 3;
        default: ;
      endcase
    end
    if (ecmd == 13) m_pwr = anyo ? 2 : 1;
    if (ecmd == 6 || ecmd == 14) m_pwr = 0;
    m_cke = ck;
    @(posedge clk);
    #2;
    check(tag, ecmd, eill);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; m_ap[i] = 0; end
    m_lock = 0; m_pwr = 0; m_cke = 1;
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = P_NOP;
    ba = 2'd0; addr = 13'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check("R1 reset", 0, 1'b0);

    apply(1, 1, P_ACT, 2'd0, 13'h0,    "R2 deselect masks");
    apply(1, 0, P_NOP, 2'd0, 13'h0,    "R2 nop");
    apply(1, 0, P_MRS, 2'd0, 13'h032,  "R2 mode load");
    apply(1, 0, P_ACT, 2'd1, 13'h1ABC, "R9 lockout edge");
    apply(1, 0, P_ACT, 2'd1, 13'h1ABC, "R9 lockout over, R4 open");
    apply(1, 0, P_ACT, 2'd1, 13'h0555, "R4 double activate, R10");
    apply(1, 0, P_MRS, 2'd1, 13'h0,    "R8 extended load with open bank");
    apply(1, 0, P_ACT, 2'd2, 13'h0F0F, "R10 no lockout from illegal load");
    apply(1, 0, P_RD,  2'd0, 13'h0,    "R5 read closed bank");
    apply(1, 0, P_PRE, 2'd3, 13'h0,    "R5 precharge closed bank");
    apply(1, 0, P_WR,  2'd1, 13'h0010, "R2 write");
    apply(1, 0, P_RD,  2'd1, 13'h0400, "R7 read with auto-precharge");
    apply(1, 0, P_RD,  2'd1, 13'h0000, "R5 read during pending precharge");
    apply(1, 0, P_NOP, 2'd0, 13'h0,    "R7 pending");
    apply(1, 0, P_NOP, 2'd0, 13'h0,    "R7 last open edge");
    apply(1, 0, P_NOP, 2'd0, 13'h0,    "R7 closing edge");
    apply(1, 0, P_PRE, 2'd2, 13'h0,    "R6 single precharge");
    apply(1, 0, P_ACT, 2'd0, 13'h1111, "R4 bank 0");
    apply(1, 0, P_ACT, 2'd3, 13'h1333, "R4 bank 3");
    apply(1, 0, P_PRE, 2'd1, 13'h0400, "R6 all-bank precharge ignores BA");
    apply(1, 0, P_BST, 2'd0, 13'h0,    "R2 burst stop");
    apply(1, 0, P_REF, 2'd0, 13'h0,    "R2 auto refresh idle");
    apply(1, 0, P_ACT, 2'd0, 13'h0222, "R4 reopen");
    apply(0, 0, P_NOP, 2'd0, 13'h0,    "R11 active power-down");
    apply(0, 1, P_NOP, 2'd0, 13'h0,    "R3 hold");
    apply(1, 1, P_NOP, 2'd0, 13'h0,    "R3 power-down exit");
    apply(1, 0, P_PRE, 2'd0, 13'h0,    "R6 close bank 0");
    apply(0, 1, P_NOP, 2'd0, 13'h0,    "R11 precharge power-down");
    apply(1, 1, P_NOP, 2'd0, 13'h0,    "R3 exit");
    apply(0, 0, P_REF, 2'd0, 13'h0,    "R3 self-refresh entry");
    apply(0, 1, P_NOP, 2'd0, 13'h0,    "R11 self refresh hold");
    apply(1, 1, P_NOP, 2'd0, 13'h0,    "R3 self-refresh exit");
    apply(1, 0, P_ACT, 2'd3, 13'h0777, "R4 bank 3 again");
    apply(0, 0, P_REF, 2'd0, 13'h0,    "R8 self refresh with open bank, R10");
    apply(1, 1, P_NOP, 2'd0, 13'h0,    "R3 exit after refused entry");
    apply(1, 0, P_PRE, 2'd0, 13'h0400, "R6 all close");

    for (int n = 0; n < 4000; n++) begin
      bit ck, cs;
      logic [2:0] pins;
      ck   = ($urandom_range(0, 99) < 92);
      cs   = ($urandom_range(0, 99) < 10);
      pins = 3'($urandom_range(0, 7));
      apply(ck, cs, pins, 2'($urandom_range(0, 3)), 13'($urandom),
            "R12 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule